// File: doc/BRIEF.md
# Programmable Pixel Clock Control Unit

This unit sits in the clock section of a display controller. It holds two 16-bit synthesizer words, one for the memory clock and one for the video clock. Software loads each word one byte at a time through a small indexed register port. A write to a clock-word byte is accepted only while a separately held control byte carries the unlock pattern: bit 7 set and bit 1 clear. All other writes to those bytes are dropped.

The video word packs three fields. The multiplier M is in bits 6:0, the divider N in bits 11:7 and the post-scaler K in bit 12. The unit decodes these fields and computes the synthesized frequency as an unsigned integer in hertz: floor((M + 8) × 14318180 / ((N + 2) × 2^K)). A restoring divider produces one quotient bit per cycle. It restarts on every accepted video-word byte write.

A two-bit source select picks the pixel clock frequency that is reported. The choices are two fixed crystal values and the synthesized value. The unit does not generate a clock. It reports frequency numbers that downstream timing logic consumes.

Top module: `pclk_ctl`

## Requirements
- R1: A synchronous active-high reset clears the memory word, the video word, the control byte and the select to zero. It drops synth_valid and calc_busy. After reset, reg_rdata reads zero at every offset.
- R2: With the write gate open, a write to offset 2 loads bits 7:0 of the memory word and a write to offset 3 loads bits 15:8. The other byte keeps its value.
- R3: With the write gate open, a write to offset 4 loads bits 7:0 of the video word and a write to offset 5 loads bits 15:8. The other byte keeps its value.
- R4: The write gate is open only when control byte bit 1 is 0 and bit 7 is 1. With the gate closed, writes to offsets 2 to 5 change neither clock word and do not start a computation.
- R5: Offset 0 holds the control byte and offset 1 holds the select in bits 1:0. Writes to offsets 0 and 1 are never gated. Offsets 0 to 5 read back their current contents whatever the gate state, and offset 1 reads zero in bits 7:2.
- R6: The field outputs are mul_m = video word bits 6:0, div_n = bits 11:7 and post_k = bit 12. Video word bits 15:13 are stored and read back but do not affect the result.
- R7: A completed computation yields synth_hz = floor((M+8)×14318180 / ((N+2)<<K)).
- R8: An accepted video-word write starts a computation. calc_busy stays high for 32 cycles, after which calc_done pulses for one cycle while synth_hz takes the new value. A further accepted video write during a computation restarts it, and the interrupted computation produces no done pulse.
- R9: synth_hz and synth_valid change only in the cycle calc_done is high. synth_valid stays low from reset until the first completion.
- R10: The select decides pix_hz. Value 0 gives 25174800 and value 1 gives 28636360. Value 2 gives synth_hz, and value 3 falls back to 25174800. pix_valid is low only when the select is 2 and synth_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data at reg_addr (combinational) |
| mem_word | output | 16 | Memory clock synthesizer word |
| vid_word | output | 16 | Video clock synthesizer word |
| mul_m | output | 7 | Decoded multiplier field |
| div_n | output | 5 | Decoded divider field |
| post_k | output | 1 | Decoded post-scaler bit |
| calc_busy | output | 1 | Frequency computation in progress |
| calc_done | output | 1 | One-cycle completion pulse |
| synth_hz | output | 32 | Last completed synthesized frequency in Hz |
| synth_valid | output | 1 | synth_hz holds a completed result |
| pix_hz | output | 32 | Selected pixel clock frequency in Hz |
| pix_valid | output | 1 | pix_hz is meaningful |

## Verification
The bench builds the unit with its default parameters: 7/5/1-bit M/N/K fields, offsets 8 and 2, a 32-bit frequency and 16-bit words. These values make the full 32-cycle division visible. They also bring the extreme field values within reach of the test: M=127, N=31, K=1 gives the largest numerator and denominator. A scoreboard predicts each result from 64-bit arithmetic, and it discards predictions that a restarting write overtakes. The bench also measures the busy window against the 32-cycle latency.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam logic [2:0] CTRL_OFS = 3'd0;
  localparam logic [2:0] SEL_OFS  = 3'd1;
  localparam int unsigned MEM_BASE = 2;

  localparam logic [1:0] SRC_FIX0  = 2'd0;
  localparam logic [1:0] SRC_FIX1  = 2'd1;
  localparam logic [1:0] SRC_SYNTH = 2'd2;

  // Unlock pattern for synthesizer-word writes
  function automatic logic unlock_ok(input logic [7:0] ctl);
    return (ctl[7] == 1'b1) && (ctl[1] == 1'b0);
  endfunction
endpackage

// File: rtl/pclk_regs.sv
module pclk_regs
  import pclk_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SEL_W  = 2,
  parameter int DEC_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [SEL_W-1:0]  sel,
  output logic              gate,
  output logic [WORD_W-1:0] mem_word,
  output logic [WORD_W-1:0] vid_word,
  output logic [DEC_W-1:0]  vid_next_lo,
  output logic              vid_start
);
  localparam int LANES    = WORD_W / 8;
  localparam int VID_BASE = MEM_BASE + LANES;

  logic [7:0]        ctl_q;
  logic [SEL_W-1:0]  sel_q;
  logic [WORD_W-1:0] mem_q, vid_q, mem_d, vid_d;
  logic [LANES-1:0]  mem_hit, vid_hit;

  assign gate = unlock_ok(ctl_q);

  // One lane decode per byte of each word
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mem_hit[g] = (addr == 3'(MEM_BASE + g));
    assign vid_hit[g] = (addr == 3'(VID_BASE + g));
    assign mem_d[8*g +: 8] = (we && gate && mem_hit[g]) ? wdata : mem_q[8*g +: 8];
    assign vid_d[8*g +: 8] = (we && gate && vid_hit[g]) ? wdata : vid_q[8*g +: 8];
  end

  assign vid_start   = we && gate && (|vid_hit);
  assign vid_next_lo = vid_d[DEC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      sel_q <= '0;
      mem_q <= '0;
      vid_q <= '0;
    end else begin
      mem_q <= mem_d;
      vid_q <= vid_d;
      if (we && addr == CTRL_OFS) ctl_q <= wdata;
      if (we && addr == SEL_OFS)  sel_q <= wdata[SEL_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == CTRL_OFS) rdata = ctl_q;
    if (addr == SEL_OFS)  rdata = 8'(sel_q);
    for (int i = 0; i < LANES; i++) begin
      if (mem_hit[i]) rdata = mem_q[8*i +: 8];
      if (vid_hit[i]) rdata = vid_q[8*i +: 8];
    end
  end

  assign sel      = sel_q;
  assign mem_word = mem_q;
  assign vid_word = vid_q;
endmodule

// File: rtl/pclk_div.sv
module pclk_div #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quot,
  output logic             valid
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, den_q, rem_n;
  logic [NUM_W-1:0] quo_q, quo_n, res_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q, val_q;
  logic [DEN_W:0]   rem_sh, diff;
  logic             fits, last;

  // One restoring step: shift in the next dividend bit, try to subtract
  always_comb begin
    rem_sh = {rem_q, quo_q[NUM_W-1]};
    diff   = rem_sh - {1'b0, den_q};
    fits   = ~diff[DEN_W];
    rem_n  = fits ? diff[DEN_W-1:0] : rem_sh[DEN_W-1:0];
    quo_n  = {quo_q[NUM_W-2:0], fits};
    last   = (cnt_q == CNT_W'(NUM_W - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      res_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      val_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        rem_q  <= '0;
        quo_q  <= num;
        den_q  <= den;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= rem_n;
        quo_q <= quo_n;
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= quo_n;
          val_q  <= 1'b1;
        end
      end
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign quot  = res_q;
  assign valid = val_q;
endmodule

// File: rtl/pclk_ctl.sv
module pclk_ctl
  import pclk_pkg::*;
#(
  parameter int          WORD_W  = 16,
  parameter int          FREQ_W  = 32,
  parameter int          M_W     = 7,
  parameter int          N_W     = 5,
  parameter int          K_W     = 1,
  parameter int          M_OFS   = 8,
  parameter int          N_OFS   = 2,
  parameter int unsigned REF_HZ  = 14318180,
  parameter int unsigned FIX0_HZ = 25174800,
  parameter int unsigned FIX1_HZ = 28636360
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [WORD_W-1:0] mem_word,
  output logic [WORD_W-1:0] vid_word,
  output logic [M_W-1:0]    mul_m,
  output logic [N_W-1:0]    div_n,
  output logic [K_W-1:0]    post_k,
  output logic              calc_busy,
  output logic              calc_done,
  output logic [FREQ_W-1:0] synth_hz,
  output logic              synth_valid,
  output logic [FREQ_W-1:0] pix_hz,
  output logic              pix_valid
);
  localparam int N_LSB = M_W;
  localparam int K_LSB = M_W + N_W;
  localparam int DEC_W = K_LSB + K_W;
  localparam int DEN_W = N_W + 1 + (2**K_W) - 1;

  function automatic logic [FREQ_W-1:0] synth_num(input logic [M_W-1:0] m);
    logic [63:0] t;
    t = (64'(m) + 64'(M_OFS)) * 64'(REF_HZ);
    return t[FREQ_W-1:0];
  endfunction

  function automatic logic [DEN_W-1:0] synth_den(input logic [N_W-1:0] n,
                                                 input logic [K_W-1:0] k);
    logic [DEN_W-1:0] b;
    b = DEN_W'(n) + DEN_W'(N_OFS);
    return b << k;
  endfunction

  // Named internal events for the checker
  logic [1:0]       sel_q;
  logic             wr_gate;
  logic             vid_start;
  logic [DEC_W-1:0] vid_next_lo;
  logic [FREQ_W-1:0] num_w;
  logic [DEN_W-1:0]  den_w;

  pclk_regs #(.WORD_W(WORD_W), .SEL_W(2), .DEC_W(DEC_W)) regs_i (
    .clk         (clk),
    .rst         (rst),
    .we          (reg_we),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .rdata       (reg_rdata),
    .sel         (sel_q),
    .gate        (wr_gate),
    .mem_word    (mem_word),
    .vid_word    (vid_word),
    .vid_next_lo (vid_next_lo),
    .vid_start   (vid_start)
  );

  assign num_w = synth_num(vid_next_lo[M_W-1:0]);
  assign den_w = synth_den(vid_next_lo[K_LSB-1:N_LSB], vid_next_lo[DEC_W-1:K_LSB]);

  pclk_div #(.NUM_W(FREQ_W), .DEN_W(DEN_W)) div_i (
    .clk   (clk),
    .rst   (rst),
    .start (vid_start),
    .num   (num_w),
    .den   (den_w),
    .busy  (calc_busy),
    .done  (calc_done),
    .quot  (synth_hz),
    .valid (synth_valid)
  );

  assign mul_m  = vid_word[M_W-1:0];
  assign div_n  = vid_word[K_LSB-1:N_LSB];
  assign post_k = vid_word[DEC_W-1:K_LSB];

  always_comb begin
    pix_valid = 1'b1;
    unique case (sel_q)
      SRC_FIX1:  pix_hz = FREQ_W'(FIX1_HZ);
      SRC_SYNTH: begin
        pix_hz    = synth_hz;
        pix_valid = synth_valid;
      end
      default:   pix_hz = FREQ_W'(FIX0_HZ);
    endcase
  end
endmodule

// File: rtl/pclk_ctl_chk.sv
module pclk_ctl_chk #(
  parameter int WORD_W = 16,
  parameter int FREQ_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic              wr_gate,
  input logic              vid_start,
  input logic [WORD_W-1:0] mem_word,
  input logic [WORD_W-1:0] vid_word,
  input logic              calc_busy,
  input logic              calc_done,
  input logic [FREQ_W-1:0] synth_hz,
  input logic              synth_valid,
  input logic              pix_valid
);
  localparam int LANES = WORD_W / 8;
  localparam int LAST  = 2 + 2 * LANES - 1;
  localparam int CNT_W = $clog2(FREQ_W + 2);

  logic [CNT_W-1:0] run_cnt;
  logic             word_hit;

  assign word_hit = (reg_addr >= 3'd2) && (reg_addr <= 3'(LAST));

  always_ff @(posedge clk) begin
    if (rst)            run_cnt <= '0;
    else if (vid_start) run_cnt <= '0;
    else if (calc_busy) run_cnt <= run_cnt + 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mem_word == '0 && vid_word == '0 && !calc_busy && !synth_valid));

  p_locked_words_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_we && word_hit && !wr_gate) |=> ($stable(mem_word) && $stable(vid_word)));

  p_locked_nostart_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_gate |-> !vid_start);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    calc_done |=> !calc_done);

  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    calc_done |-> (run_cnt == CNT_W'(FREQ_W)));

  p_hold_result_r9: assert property (@(posedge clk) disable iff (rst)
    !calc_done |-> ($stable(synth_hz) && $stable(synth_valid)));

  p_valid_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    synth_valid |=> synth_valid);

  p_pix_valid_r10: assert property (@(posedge clk) disable iff (rst)
    synth_valid |-> pix_valid);
endmodule

bind pclk_ctl pclk_ctl_chk #(.WORD_W(WORD_W), .FREQ_W(FREQ_W)) chk_i (.*);

// File: tb/pclk_ctl_tb_top.sv
`timescale 1ns/1ps
module pclk_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] mem_word, vid_word;
  logic [6:0]  mul_m;
  logic [4:0]  div_n;
  logic [0:0]  post_k;
  logic        calc_busy, calc_done, synth_valid, pix_valid;
  logic [31:0] synth_hz, pix_hz;

  always #2.5 clk = ~clk;

  pclk_ctl dut_i (.*);

  int n_vec = 0;
  int n_bad = 0;
  int busy_run = 0;
  logic [31:0] exp_q[$];
  logic [31:0] synth_m = '0;
  logic        synth_v_m = 1'b0;
  logic [7:0]  ctl_m = '0;
  logic [15:0] vid_m = '0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_hz(input logic [15:0] w);
    longint num, den;
    num = (longint'(w & 16'h7F) + 8) * 14318180;
    den = (longint'((w >> 7) & 16'h1F) + 2) * (((w >> 12) & 1) != 0 ? 2 : 1);
    return 32'(num / den);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic was_busy, acc;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    was_busy = calc_busy;
    acc = ctl_m[7] && !ctl_m[1] && (a == 3'd4 || a == 3'd5);
    @(posedge clk);
    #1 reg_we = 1'b0;
    if (a == 3'd0) ctl_m = d;
    if (acc) begin
      if (a == 3'd4) vid_m[7:0] = d; else vid_m[15:8] = d;
      if (was_busy && exp_q.size() > 0) void'(exp_q.pop_back());
      exp_q.push_back(model_hz(vid_m));
      busy_run = 0;
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, reg_rdata, exp);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !calc_busy) break;
    end
    chk("R8 pending results drained", exp_q.size(), 0);
  endtask

  task automatic set_vid(input logic [15:0] w);
    wr(3'd4, w[7:0]);
    wr(3'd5, w[15:8]);
    wait_idle();
  endtask

  // Monitor: compares each completion with the oldest prediction
  always @(negedge clk) begin
    if (!rst) begin
      if (calc_busy) busy_run++;
      if (calc_done) begin
        if (exp_q.size() == 0) begin
          chk("R8 unexpected done", 1, 0);
        end else begin
          synth_m = exp_q.pop_front();
          synth_v_m = 1'b1;
          chk("R7 synth_hz", synth_hz, synth_m);
          chk("R8 busy cycles", busy_run, 32);
          chk("R9 synth_valid on done", synth_valid, 1);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), 8'h00, "R1 reset readback");
    chk("R1 synth_valid", synth_valid, 0);
    chk("R1 calc_busy", calc_busy, 0);
    chk("R10 pix_hz sel0", pix_hz, 25174800);
    // R4 gate closed by control byte 0
    wr(3'd4, 8'h55);
    rd(3'd4, 8'h00, "R4 locked write ctl=00");
    chk("R4 no start", calc_busy, 0);
    wr(3'd0, 8'h82);
    wr(3'd2, 8'h77);
    rd(3'd2, 8'h00, "R4 locked write ctl=82");
    rd(3'd0, 8'h82, "R5 control readback");
    // R10 synth select before any result
    wr(3'd1, 8'h02);
    @(negedge clk);
    chk("R10 pix_valid without result", pix_valid, 0);
    // R2 memory word, open gate
    wr(3'd0, 8'h80);
    wr(3'd2, 8'h34);
    wr(3'd3, 8'h12);
    @(negedge clk) chk("R2 mem word", mem_word, 16'h1234);
    wr(3'd2, 8'hAB);
    @(negedge clk) chk("R2 high byte kept", mem_word, 16'h12AB);
    // R3 / R7 / R8: video word, low then high (restart)
    set_vid(16'h0000);
    chk("R3 vid word", vid_word, 16'h0000);
    chk("R10 pix_hz synth", pix_hz, synth_m);
    chk("R10 pix_valid", pix_valid, 1);
    set_vid(16'h1FFF);
    chk("R6 mul_m", mul_m, 7'h7F);
    chk("R6 div_n", div_n, 5'h1F);
    chk("R6 post_k", post_k, 1);
    set_vid(16'h0A5C);
    chk("R3 vid word", vid_word, 16'h0A5C);
    // R6: upper bits ignored; R9 hold during busy
    wr(3'd5, 8'hEA);
    @(negedge clk);
    chk("R9 busy after start", calc_busy, 1);
    chk("R9 synth held", synth_hz, synth_m);
    repeat (10) @(negedge clk);
    chk("R9 synth held late", synth_hz, synth_m);
    wait_idle();
    chk("R6 upper bits ignored", synth_hz, model_hz(16'h0A5C));
    chk("R6 k decode", post_k, 0);
    // R3 low byte only keeps high byte
    wr(3'd4, 8'h11);
    wait_idle();
    chk("R3 high byte kept", vid_word, 16'hEA11);
    // R10 select variants
    wr(3'd1, 8'hFD);
    rd(3'd1, 8'h01, "R5 select readback");
    chk("R10 pix_hz sel1", pix_hz, 28636360);
    wr(3'd1, 8'h03);
    @(negedge clk) chk("R10 pix_hz sel3", pix_hz, 25174800);
    // R5 readback with gate closed; R4 writes dropped
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h00);
    wr(3'd5, 8'h00);
    rd(3'd3, 8'h12, "R5 mem hi readback locked");
    rd(3'd5, 8'hEA, "R5 vid hi readback locked");
    rd(3'd4, 8'h11, "R5 vid lo readback locked");
    chk("R4 no start when locked", calc_busy, 0);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule